// File: doc/BRIEF.md
# Serial Byte Receiver with Idle-Qualified Resynchronisation

This block receives asynchronous serial characters on one input line. Each character is one start bit, eight data bits sent least significant bit first, and one stop bit. It uses a clock enable that pulses sixteen times per bit period. The line is first passed through a two-stage synchronizer. A falling level is taken as a possible start bit. That start bit is confirmed half a bit later. Each bit after it is sampled in the middle of its bit cell. Each completed character comes out as a byte together with a one-clock strobe, plus a flag that marks a bad stop bit.

A stream with no idle time between characters can be read at more than one alignment, and every one of those readings can look legal. To get out of a wrong alignment, the receiver stops hunting for start bits after any bad stop bit. It starts hunting again only after the line has stayed high for a full character time without a break. A separate output shows a break, meaning the line has been held low for longer than one whole character.

Top module: `uart_rx_resync`

## Requirements
- R1: Every accepted character produces `rx_valid` high for exactly one clock. In that clock, `rx_byte` holds the eight data bits, with the first bit received in bit 0.
- R2: A start bit is confirmed on the eighth enable tick after the low level is first seen. If the line is high at that point, the low level is treated as a glitch and no byte is produced.
- R3: If the stop bit is sampled low, the byte is still delivered with `rx_valid`, and `rx_frame_err` is high in that same clock. `rx_frame_err` is never high without `rx_valid`.
- R4: After a framing error, any low level on the line is ignored as a start bit until the line has been high for 160 consecutive enable ticks (ten bit times). Any low sample restarts that count.
- R5: When no framing error occurs, characters sent back to back with a single stop bit and no idle gap are all received. A continuous repeat of the bit pattern 0,0,1,1,1,1,1,1,0,1, taken from its first zero, gives bytes of 0x7E.
- R6: `rx_break` is high while the line has been low for more than 160 consecutive enable ticks. It drops within a few clocks of the line going high.
- R7: After reset, `rx_valid`, `rx_frame_err` and `rx_break` are low, and the receiver accepts a start bit straight away.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Enable pulse at 16 times the bit rate |
| rxd | input | 1 | Asynchronous serial input, idle high |
| rx_byte | output | 8 | Last received data byte |
| rx_valid | output | 1 | One-clock strobe for a received byte |
| rx_frame_err | output | 1 | Stop bit was low for this byte |
| rx_break | output | 1 | Line held low longer than one character |

## Verification
The bench sends a character with a low stop bit. It then sends a second character after only three bit times of idle, which a receiver that resyncs at once would wrongly accept. After that it checks that the same character is accepted once eleven idle bit times have passed. A short low pulse tests glitch rejection: a design that skips the half-bit confirmation would output a byte made of ones. Back-to-back 0x7E characters catch a design that wrongly demands idle time between every frame. A long low hold checks that the break output does not rise too early, does rise after a frame time, and falls when the line is released.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], d_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/uart_rx_idle_guard.sv
module uart_rx_idle_guard #(
  parameter int OVS       = 16,
  parameter int DATA_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rx_s,
  input  logic disarm_i,
  output logic armed_o,
  output logic brk_o
);
  localparam int FRAME_TICKS = OVS * (DATA_BITS + 2);
  localparam int CW = $clog2(FRAME_TICKS + 2);
  localparam logic [CW-1:0] HI_MAX = CW'(FRAME_TICKS);
  localparam logic [CW-1:0] LO_MAX = CW'(FRAME_TICKS + 1);

  logic [CW-1:0] hi_q, hi_d, lo_q, lo_d;
  logic          armed_q, armed_d;

  always_comb begin
    hi_d    = hi_q;
    lo_d    = lo_q;
    armed_d = armed_q;
    if (!rx_s)                       hi_d = '0;
    else if (tick && hi_q != HI_MAX) hi_d = hi_q + 1'b1;
    if (rx_s)                        lo_d = '0;
    else if (tick && lo_q != LO_MAX) lo_d = lo_q + 1'b1;
    if (disarm_i)
      armed_d = 1'b0;
    else if (rx_s && tick && hi_q == HI_MAX - 1'b1)
      armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q    <= '0;
      lo_q    <= '0;
      armed_q <= 1'b1;
    end else begin
      hi_q    <= hi_d;
      lo_q    <= lo_d;
      armed_q <= armed_d;
    end
  end

  assign armed_o = armed_q;
  assign brk_o   = (lo_q == LO_MAX);

  AST_DISARM_AFTER_FERR: assert property (@(posedge clk) disable iff (!rst_n)
    disarm_i |=> !armed_o);  // R4
  AST_REARM_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_o && !rx_s) |=> !armed_o);  // R4
  AST_BREAK_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    brk_o |-> $past(!rx_s));  // R6
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OVS       = 16,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 rx_s,
  input  logic                 armed,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 valid_o,
  output logic                 ferr_o,
  output logic                 disarm_o
);
  localparam int TW = $clog2(OVS);
  localparam int BW = $clog2(DATA_BITS);
  localparam logic [TW-1:0] T_LAST = TW'(OVS - 1);
  localparam logic [TW-1:0] T_HALF = TW'(OVS / 2 - 1);
  localparam logic [BW-1:0] B_LAST = BW'(DATA_BITS - 1);

  rx_state_e            state_q, state_d;
  logic [TW-1:0]        tcnt_q, tcnt_d;
  logic [BW-1:0]        bcnt_q, bcnt_d;
  logic [DATA_BITS-1:0] sh_q, sh_d, data_q, data_d;
  logic                 valid_q, valid_d, ferr_q, ferr_d;

  always_comb begin
    state_d = state_q;
    tcnt_d  = tcnt_q;
    bcnt_d  = bcnt_q;
    sh_d    = sh_q;
    data_d  = data_q;
    valid_d = 1'b0;
    ferr_d  = 1'b0;
    if (tick) begin
      unique case (state_q)
        ST_IDLE: begin
          if (!rx_s && armed) begin
            state_d = ST_START;
            tcnt_d  = '0;
          end
        end
        ST_START: begin
          if (tcnt_q == T_HALF) begin
            tcnt_d  = '0;
            bcnt_d  = '0;
            state_d = rx_s ? ST_IDLE : ST_DATA;
          end else begin
            tcnt_d = tcnt_q + 1'b1;
          end
        end
        ST_DATA: begin
          if (tcnt_q == T_LAST) begin
            tcnt_d = '0;
            sh_d   = {rx_s, sh_q[DATA_BITS-1:1]};
            if (bcnt_q == B_LAST) state_d = ST_STOP;
            else                  bcnt_d  = bcnt_q + 1'b1;
          end else begin
            tcnt_d = tcnt_q + 1'b1;
          end
        end
        ST_STOP: begin
          if (tcnt_q == T_LAST) begin
            tcnt_d  = '0;
            valid_d = 1'b1;
            ferr_d  = !rx_s;
            data_d  = sh_q;
            state_d = ST_IDLE;
          end else begin
            tcnt_d = tcnt_q + 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tcnt_q  <= '0;
      bcnt_q  <= '0;
      sh_q    <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      tcnt_q  <= tcnt_d;
      bcnt_q  <= bcnt_d;
      sh_q    <= sh_d;
      data_q  <= data_d;
      valid_q <= valid_d;
      ferr_q  <= ferr_d;
    end
  end

  assign data_o   = data_q;
  assign valid_o  = valid_q;
  assign ferr_o   = ferr_q;
  assign disarm_o = valid_d & ferr_d;

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);  // R1
  AST_FERR_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    ferr_o |-> valid_o);  // R3
  AST_GLITCH_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START && tick && tcnt_q == T_HALF && rx_s) |=> state_q == ST_IDLE);  // R2
  AST_DISARMED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !armed) |=> state_q == ST_IDLE);  // R4
endmodule

// File: rtl/uart_rx_resync.sv
module uart_rx_resync #(
  parameter int OVS       = 16,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 os_tick,
  input  logic                 rxd,
  output logic [DATA_BITS-1:0] rx_byte,
  output logic                 rx_valid,
  output logic                 rx_frame_err,
  output logic                 rx_break
);
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  logic       rx_s, armed, disarm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  uart_rx_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .d_i(rxd), .q_o(rx_s)
  );

  uart_rx_idle_guard #(.OVS(OVS), .DATA_BITS(DATA_BITS)) u_guard (
    .clk(clk), .rst_n(rst_int_n), .tick(os_tick), .rx_s(rx_s),
    .disarm_i(disarm), .armed_o(armed), .brk_o(rx_break)
  );

  uart_rx_frame #(.OVS(OVS), .DATA_BITS(DATA_BITS)) u_frame (
    .clk(clk), .rst_n(rst_int_n), .tick(os_tick), .rx_s(rx_s),
    .armed(armed), .data_o(rx_byte), .valid_o(rx_valid),
    .ferr_o(rx_frame_err), .disarm_o(disarm)
  );
endmodule

// File: tb/uart_rx_resync_tb.sv
module uart_rx_resync_tb_top;
  localparam int BIT_CLKS = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       os_tick = 1'b0;
  logic       rxd = 1'b1;
  logic [7:0] rx_byte;
  logic       rx_valid, rx_frame_err, rx_break;

  int tests = 0;
  int fails = 0;
  int cap_n = 0;
  logic [7:0] cap_data [0:63];
  logic       cap_ferr [0:63];

  // {gap in bit times after frame, data byte}
  localparam logic [11:0] VEC [0:6] = '{12'h1_55, 12'h0_A3, 12'h2_00,
                                        12'h0_FF, 12'h3_01, 12'h0_80, 12'h2_C6};

  always #5 clk = ~clk;

  always @(posedge clk) os_tick <= ~os_tick;

  uart_rx_resync dut_i (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
    .rx_byte(rx_byte), .rx_valid(rx_valid),
    .rx_frame_err(rx_frame_err), .rx_break(rx_break)
  );

  always @(negedge clk) begin
    if (rx_valid && cap_n < 64) begin
      cap_data[cap_n] = rx_byte;
      cap_ferr[cap_n] = rx_frame_err;
      cap_n = cap_n + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle_bits(input int n);
    @(posedge clk) rxd <= 1'b1;
    repeat (n * BIT_CLKS - 1) @(posedge clk);
  endtask

  task automatic send(input logic [7:0] b, input logic stop);
    logic [9:0] fr;
    fr = {stop, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      @(posedge clk) rxd <= fr[i];
      repeat (BIT_CLKS - 1) @(posedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int base;
    repeat (4) @(posedge clk);
    #1;
    chk("R7 valid in reset", int'(rx_valid), 0);
    chk("R7 break in reset", int'(rx_break), 0);
    @(posedge clk) rst_n <= 1'b1;
    repeat (8) @(posedge clk);
    #1;
    chk("R7 ferr after reset", int'(rx_frame_err), 0);

    // R7: first frame accepted immediately after reset; R1, R5 table walk
    for (int v = 0; v < 7; v++) begin
      send(VEC[v][7:0], 1'b1);
      if (VEC[v][11:8] != 0) idle_bits(int'(VEC[v][11:8]));
    end
    idle_bits(2);
    #1;
    chk("R1 byte count", cap_n, 7);
    for (int v = 0; v < 7; v++) begin
      chk("R1 data", int'(cap_data[v]), int'(VEC[v][7:0]));
      chk("R5 no ferr", int'(cap_ferr[v]), 0);
    end

    // R5: continuous 0x7E stream
    base = cap_n;
    for (int k = 0; k < 4; k++) send(8'h7E, 1'b1);
    idle_bits(2);
    #1;
    chk("R5 stream count", cap_n - base, 4);
    for (int k = 0; k < 4; k++) chk("R5 stream data", int'(cap_data[base + k]), 8'h7E);

    // R2: short low glitch rejected, then normal byte
    base = cap_n;
    @(posedge clk) rxd <= 1'b0;
    repeat (5) @(posedge clk);
    @(posedge clk) rxd <= 1'b1;
    idle_bits(12);
    #1;
    chk("R2 glitch ignored", cap_n - base, 0);
    send(8'h33, 1'b1);
    idle_bits(2);
    #1;
    chk("R2 byte after glitch", int'(cap_data[base]), 8'h33);

    // R3/R4: framing error, early start ignored, later accepted
    base = cap_n;
    send(8'h3C, 1'b0);
    idle_bits(3);
    #1;
    chk("R3 ferr count", cap_n - base, 1);
    chk("R3 ferr data", int'(cap_data[base]), 8'h3C);
    chk("R3 ferr flag", int'(cap_ferr[base]), 1);
    send(8'h5A, 1'b1);
    idle_bits(2);
    #1;
    chk("R4 ignored while disarmed", cap_n - base, 1);
    idle_bits(9);
    send(8'h5A, 1'b1);
    idle_bits(2);
    #1;
    chk("R4 rearmed count", cap_n - base, 2);
    chk("R4 rearmed data", int'(cap_data[base + 1]), 8'h5A);
    chk("R4 rearmed ferr", int'(cap_ferr[base + 1]), 0);

    // R6: break detection
    base = cap_n;
    @(posedge clk) rxd <= 1'b0;
    repeat (9 * BIT_CLKS) @(posedge clk);
    #1;
    chk("R6 no early break", int'(rx_break), 0);
    repeat (3 * BIT_CLKS) @(posedge clk);
    #1;
    chk("R6 break set", int'(rx_break), 1);
    chk("R3 break byte ferr", int'(cap_ferr[base]), 1);
    chk("R3 break byte data", int'(cap_data[base]), 8'h00);
    idle_bits(1);
    #1;
    chk("R6 break cleared", int'(rx_break), 0);
    idle_bits(11);
    send(8'h81, 1'b1);
    idle_bits(2);
    #1;
    chk("R4 after break count", cap_n - base, 2);
    chk("R4 after break data", int'(cap_data[base + 1]), 8'h81);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule